// File: doc/BRIEF.md
# Concave-Potential DRAM Request Scheduler

This block chooses which pending DRAM request goes next to a single bank. Requests come from several cores, and each core keeps a separate queue for each warp. Every request records one flag at arrival: whether it hits the open row. The block stores these flags in order in each queue, so the head of a queue always carries the type of its oldest request.

Each cycle the scheduler first picks a core. It takes the core with the lowest latency tolerance among the cores that have work. Inside that core it gives each non-empty warp queue a score. The score is how much serving that queue's head would lower the core's potential, where the potential is the sum of the square roots of the queue lengths. A row hit takes one full unit off the queue length. A row miss takes off only 1/m of a unit, where m is a power of two. The queue with the largest score is granted.

The grant is combinational and valid whenever `ready_i` is high. The granted queue is popped at the next clock edge. Arrivals at that same edge are accepted.

Top module: `pfs_sched`

## Requirements
- R1: While `rst_ni` is low, and afterwards until a request arrives, `grant_valid_o` is 0. Reset empties all queues.
- R2: Raising `arr_valid_i[c*4+w]` enqueues one request into warp queue w of core c. The flag `arr_hit_i[c*4+w]` is stored with it (1 = row hit). Grants from a queue report these flags in arrival order on `grant_hit_o`.
- R3: The granted core is the core with the smallest `tol_i[c*8 +: 8]` among cores that have at least one queued request. Equal tolerances go to the lower core index.
- R4: A core with no queued request is never granted, even if its tolerance is the lowest. An empty warp queue is never granted.
- R5: The potential table is f(k) = floor(256·sqrt(k/4)) for k = 0..64, where k is a queue length in quarter units. A row-hit head in a queue of length L scores f(4L) − f(4L−4).
- R6: A row-miss head in a queue of length L scores f(4L) − f(4L−1). This corresponds to a miss-to-hit cost ratio m = 4.
- R7: Within the chosen core, the granted warp is the one with the highest score. Equal scores go to the lower warp index.
- R8: `grant_valid_o` is 1 exactly when `ready_i` is 1 and some request is queued. The grant appears in the same cycle, and the granted queue loses one entry at the next rising edge. With `ready_i` low, nothing is removed.
- R9: If an arrival and a grant hit the same queue in the same cycle, both take effect. This holds even when the queue already holds 16 entries.
- R10: An arrival to a queue holding 16 entries that is not granted in that cycle is dropped. The queue contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ready_i | input | 1 | Bank can accept a request this cycle |
| arr_valid_i | input | 8 | Per-queue arrival strobe, index core*4+warp |
| arr_hit_i | input | 8 | Row-hit flag of each arrival (1 = hit) |
| tol_i | input | 16 | Per-core latency tolerance, core c at bits c*8 +: 8 |
| grant_valid_o | output | 1 | A request is granted this cycle |
| grant_core_o | output | 1 | Granted core index |
| grant_warp_o | output | 2 | Granted warp index |
| grant_hit_o | output | 1 | Granted request is a row hit |

## Verification
The fragile point is a pop from a queue and an arrival to that same queue landing on one clock edge. The bench forces this in two ways: it fills a queue to 16 entries and then sends an arrival in a cycle where that queue is the only candidate, and its random traffic drives arrivals and `ready_i` freely. A behavioural model keeps per-queue lists of row-hit flags and recomputes the grant every cycle using square roots in real arithmetic. Any lost arrival, double count or misordered flag therefore shows up later as a grant that differs from the model.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  // floor(sqrt(n)), bitwise
  function automatic int unsigned isqrt(input int unsigned n);
    int unsigned r;
    r = 0;
    for (int b = 15; b >= 0; b--) begin
      int unsigned t;
      t = r | (32'd1 << b);
      if (t * t <= n) r = t;
    end
    return r;
  endfunction
endpackage

// File: rtl/pfs_queue.sv
module pfs_queue #(
  parameter  int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             hit_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             head_hit_o
);
  logic [DEPTH-1:0] mem_q;
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic full, do_pop, do_push;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);
  assign do_push = push_i && (!full || do_pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= hit_i;
        wr_q        <= nxt(wr_q);
      end
      if (do_pop) rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o      = cnt_q;
  assign head_hit_o = mem_q[rd_q];

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  p_pop_nonempty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0);
  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i) |=> $stable(cnt_q));
  p_push_pop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && cnt_q != '0) |=> $stable(cnt_q));
endmodule

// File: rtl/pfs_warp_pick.sv
module pfs_warp_pick #(
  parameter  int NW     = 4,
  parameter  int QMAX   = 16,
  parameter  int M_LOG2 = 2,
  parameter  int FRAC_W = 8,
  localparam int CNT_W  = $clog2(QMAX + 1),
  localparam int WARP_W = (NW > 1) ? $clog2(NW) : 1,
  localparam int TAB_N  = (QMAX << M_LOG2) + 1,
  localparam int IDX_W  = $clog2(TAB_N),
  localparam int POT_W  = FRAC_W + $clog2(QMAX) + 1,
  localparam int SH     = 2 * FRAC_W - M_LOG2
) (
  input  logic [NW-1:0][CNT_W-1:0] cnt_i,
  input  logic [NW-1:0]            hit_i,
  output logic                     valid_o,
  output logic [WARP_W-1:0]        warp_o
);
  // pot_tab[k] = 2^FRAC_W * sqrt(k / 2^M_LOG2)
  logic [POT_W-1:0] pot_tab [TAB_N];
  for (genvar k = 0; k < TAB_N; k++) begin : g_tab
    assign pot_tab[k] = POT_W'(pfs_pkg::isqrt(32'(k) << SH));
  end

  always_comb begin
    logic [POT_W-1:0] best, drop;
    logic [IDX_W-1:0] hi, lo;
    valid_o = 1'b0;
    warp_o  = '0;
    best    = '0;
    for (int w = 0; w < NW; w++) begin
      hi   = IDX_W'(cnt_i[w]) << M_LOG2;
      lo   = hit_i[w] ? hi - IDX_W'(1 << M_LOG2) : hi - 1'b1;
      drop = pot_tab[hi] - pot_tab[lo];
      if (cnt_i[w] != '0 && (!valid_o || drop > best)) begin
        valid_o = 1'b1;
        best    = drop;
        warp_o  = WARP_W'(w);
      end
    end
  end
endmodule

// File: rtl/pfs_core_pick.sv
module pfs_core_pick #(
  parameter  int NC     = 2,
  parameter  int TOL_W  = 8,
  localparam int CORE_W = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic [NC-1:0]            pend_i,
  input  logic [NC-1:0][TOL_W-1:0] tol_i,
  output logic                     valid_o,
  output logic [CORE_W-1:0]        core_o
);
  always_comb begin
    logic [TOL_W-1:0] best;
    valid_o = 1'b0;
    core_o  = '0;
    best    = '0;
    for (int c = 0; c < NC; c++) begin
      if (pend_i[c] && (!valid_o || tol_i[c] < best)) begin
        valid_o = 1'b1;
        best    = tol_i[c];
        core_o  = CORE_W'(c);
      end
    end
  end
endmodule

// File: rtl/pfs_sched.sv
module pfs_sched #(
  parameter  int NC     = 2,
  parameter  int NW     = 4,
  parameter  int QMAX   = 16,
  parameter  int TOL_W  = 8,
  parameter  int M_LOG2 = 2,
  parameter  int FRAC_W = 8,
  localparam int NQ     = NC * NW,
  localparam int CNT_W  = $clog2(QMAX + 1),
  localparam int CORE_W = (NC > 1) ? $clog2(NC) : 1,
  localparam int WARP_W = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ready_i,
  input  logic [NQ-1:0]       arr_valid_i,
  input  logic [NQ-1:0]       arr_hit_i,
  input  logic [NC*TOL_W-1:0] tol_i,
  output logic                grant_valid_o,
  output logic [CORE_W-1:0]   grant_core_o,
  output logic [WARP_W-1:0]   grant_warp_o,
  output logic                grant_hit_o
);
  logic [NQ-1:0][CNT_W-1:0]  cnt;
  logic [NQ-1:0]             head_hit;
  logic [NQ-1:0]             pop_vec;
  logic [NC-1:0]             pend;
  logic [NC-1:0][WARP_W-1:0] wsel;
  logic [NC-1:0][TOL_W-1:0]  tol;
  logic                      core_valid;
  logic [CORE_W-1:0]         core_sel;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    pfs_queue #(.DEPTH(QMAX)) u_q (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .push_i    (arr_valid_i[q]),
      .hit_i     (arr_hit_i[q]),
      .pop_i     (pop_vec[q]),
      .cnt_o     (cnt[q]),
      .head_hit_o(head_hit[q])
    );
    assign pop_vec[q] = grant_valid_o
                        && (int'(grant_core_o) == q / NW)
                        && (int'(grant_warp_o) == q % NW);
  end

  for (genvar c = 0; c < NC; c++) begin : g_core
    assign tol[c] = tol_i[c*TOL_W +: TOL_W];
    pfs_warp_pick #(.NW(NW), .QMAX(QMAX), .M_LOG2(M_LOG2), .FRAC_W(FRAC_W)) u_wp (
      .cnt_i  (cnt[c*NW +: NW]),
      .hit_i  (head_hit[c*NW +: NW]),
      .valid_o(pend[c]),
      .warp_o (wsel[c])
    );
  end

  pfs_core_pick #(.NC(NC), .TOL_W(TOL_W)) u_cp (
    .pend_i (pend),
    .tol_i  (tol),
    .valid_o(core_valid),
    .core_o (core_sel)
  );

  assign grant_valid_o = ready_i && core_valid;
  assign grant_core_o  = core_sel;
  assign grant_warp_o  = wsel[core_sel];
  assign grant_hit_o   = head_hit[int'(core_sel) * NW + int'(wsel[core_sel])];

  p_ready_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> ready_i);
  p_one_pop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pop_vec));
  p_grant_nonempty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> cnt[int'(grant_core_o) * NW + int'(grant_warp_o)] != '0);
  for (genvar c = 0; c < NC; c++) begin : g_chk
    p_core_min_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_valid_o && pend[c]) |-> tol[grant_core_o] <= tol[c]);
  end
endmodule

// File: tb/sim_pfs_sched.sv
`timescale 1ns/1ps
module sim_pfs_sched;
  localparam int NC = 2, NW = 4, NQ = 8, QMAX = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rdy = 1'b0;
  logic [NQ-1:0] av = '0, ah = '0;
  logic [15:0] tol = '0;
  logic gv, gc, gh;
  logic [1:0] gw;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  bit mq [NQ][$];
  bit e_v, e_h;
  int e_c, e_w;

  always #4 clk = ~clk;

  pfs_sched u0 (
    .clk_i(clk), .rst_ni(rst_n), .ready_i(rdy), .arr_valid_i(av), .arr_hit_i(ah),
    .tol_i(tol), .grant_valid_o(gv), .grant_core_o(gc), .grant_warp_o(gw), .grant_hit_o(gh)
  );

  function automatic int fv(input int k);
    return int'($floor($sqrt(real'(k) * 16384.0)));
  endfunction

  function automatic void expect_grant();
    int bc, bd;
    bc = -1; e_v = 0; e_c = 0; e_w = 0; e_h = 0;
    for (int c = 0; c < NC; c++) begin
      bit p = 0;
      for (int w = 0; w < NW; w++) if (mq[c*NW+w].size() > 0) p = 1;
      if (p && (bc < 0 || tol[c*8 +: 8] < tol[bc*8 +: 8])) bc = c;
    end
    if (bc < 0 || !rdy) return;
    bd = -1;
    for (int w = 0; w < NW; w++) begin
      int L, d;
      L = mq[bc*NW+w].size();
      if (L == 0) continue;
      d = mq[bc*NW+w][0] ? fv(4*L) - fv(4*L-4) : fv(4*L) - fv(4*L-1);
      if (d > bd) begin bd = d; e_w = w; end
    end
    e_v = 1; e_c = bc; e_h = mq[bc*NW+e_w][0];
  endfunction

  task automatic check(input string tag);
    n_run++;
    if (gv !== e_v || (e_v && (gc !== e_c[0] || gw !== e_w[1:0] || gh !== e_h))) begin
      n_fail++;
      $display("FAIL %s: got v=%0b c=%0d w=%0d h=%0b exp v=%0b c=%0d w=%0d h=%0b",
               tag, gv, gc, gw, gh, e_v, e_c, e_w, e_h);
    end
  endtask

  // one cycle: entered just after negedge with inputs set
  task automatic cyc(input string tag);
    #2;
    expect_grant();
    check(tag);
    @(posedge clk);
    if (e_v) void'(mq[e_c*NW+e_w].pop_front());
    for (int q = 0; q < NQ; q++)
      if (av[q] && (mq[q].size() < QMAX || (e_v && e_c*NW+e_w == q)))
        mq[q].push_back(ah[q]);
    @(negedge clk);
    av = '0; ah = '0;
  endtask

  task automatic load(input int q, input bit hit, input string tag);
    av[q] = 1'b1; ah[q] = hit;
    cyc(tag);
  endtask

  task automatic drain(input string tag);
    rdy = 1'b1;
    for (int i = 0; i < 40; i++) cyc(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung exp finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tol = {8'd40, 8'd40};
    @(negedge clk);
    // R1 during reset
    for (int i = 0; i < 3; i++) begin
      n_run++;
      if (gv !== 1'b0) begin
        n_fail++;
        $display("FAIL R1: got v=%0b exp v=0", gv);
      end
      @(negedge clk);
    end
    rst_n = 1'b1;
    rdy = 1'b1;
    cyc("R1"); cyc("R1");

    // R2: flag order
    rdy = 1'b0;
    load(2, 1, "R2"); load(2, 0, "R2"); load(2, 1, "R2"); load(2, 0, "R2");
    drain("R2");

    // R3: lower tolerance wins
    rdy = 1'b0; tol = {8'd20, 8'd50};
    load(0, 1, "R3"); load(4, 1, "R3"); load(5, 0, "R3");
    drain("R3");
    // R3: tie goes to core 0
    rdy = 1'b0; tol = {8'd33, 8'd33};
    load(1, 1, "R3"); load(6, 1, "R3");
    drain("R3");

    // R4: lowest-tolerance core empty
    rdy = 1'b0; tol = {8'd200, 8'd5};
    load(7, 0, "R4"); load(7, 1, "R4");
    drain("R4");

    // R5/R7: shortest hit queue preferred
    rdy = 1'b0; tol = {8'd9, 8'd9};
    for (int i = 0; i < 3; i++) load(0, 1, "R5");
    load(1, 1, "R5");
    for (int i = 0; i < 2; i++) load(2, 1, "R5");
    drain("R5");

    // R6: miss vs hit at same length, miss L1 vs hit L16
    rdy = 1'b0;
    load(0, 0, "R6"); load(1, 1, "R6");
    drain("R6");
    rdy = 1'b0;
    load(4, 0, "R6");
    for (int i = 0; i < 16; i++) load(5, 1, "R6");
    drain("R6");

    // R7: equal scores, lower warp
    rdy = 1'b0;
    load(3, 1, "R7"); load(0, 1, "R7");
    drain("R7");

    // R10: full queue drops arrivals; R9: full queue accepts with pop
    rdy = 1'b0;
    for (int i = 0; i < 16; i++) load(1, i[0], "R10");
    load(1, 1, "R10"); load(1, 0, "R10");
    rdy = 1'b1;
    load(1, 1, "R9"); load(1, 0, "R9");
    drain("R9");

    // R8: ready toggles with mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      av = NQ'($urandom);
      ah = NQ'($urandom);
      rdy = ($urandom % 3) != 0;
      if ((i % 50) == 0) tol = 16'($urandom);
      cyc("R8");
    end
    drain("R8");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule